// File: doc/BRIEF.md
# Message-interrupt pending bit updater

This block makes one message-signalled interrupt pending, or not pending, for a single CPU target. Two kinds of source drive its request port. The first is the command stream of a translation unit: a trigger command asks for level 1, and a clear or discard command asks for level 0. The second is the CPU acknowledge path, which asks for level 0 for any ID at 8192 or above. The requester has already chosen the target CPU, so the block sees only an interrupt ID and a level.

For each request the block first checks the current table settings. It then reads the interrupt's configuration byte from external memory. If the entry is enabled, it reads the byte of the pending bitmap that holds the interrupt's bit. It writes that byte back only when the bit really has to change. Every request that gets past the configuration check ends with a one-cycle rescan pulse. The pulse tells the priority scanner that its cached best interrupt is stale: the valid flag is dropped, the best priority returns to 0xFF, and the pending table is scanned again.

Requests are handled one at a time. The block holds its ready signal low from acceptance until it has finished the request.

Top module: `lpi_pend_engine`

## Requirements
- R1: `req_ready` is high only while the block is idle. After a request is accepted, `req_ready` stays low and `busy` stays high until the request is finished or dropped, so at most one request is in flight.
- R2: A request is dropped if `lpi_en` is low, or if either `cfg_base` or `pend_base` is zero. A dropped request makes no memory access and gives no rescan pulse.
- R3: The effective ID width is the smaller of `id_bits_fld` and MAX_IDBITS (default 15). A request is dropped, with no memory access, when the effective width is below IDBITS_MIN (default 13).
- R4: A request is dropped, with no memory access, when its ID is greater than 2^(effective width + 1) or below 8192. An ID equal to 2^(effective width + 1) is processed.
- R5: The first memory access of a processed request reads the byte at `cfg_base + (ID - 8192)`. If bit 0 of that byte is 0, the request ends after this read, with no further access and no rescan pulse.
- R6: When bit 0 of the configuration byte is 1, the next access reads the byte at `pend_base + ID/8`. The bit for the interrupt is bit `ID mod 8` of that byte.
- R7: Level 1 on a clear bit, or level 0 on a set bit, writes the pending byte back to the same address with only that bit changed. The other seven bits keep the values that were read.
- R8: If the pending bit already has the requested value, no write is issued.
- R9: Every request that passes the configuration check ends with exactly one single-cycle `rescan` pulse. The pulse comes after the write, or after the decision to skip it. `req_ready` is high again in the next cycle.
- R10: While `mem_req` is high and `mem_ack` is low, `mem_addr`, `mem_we` and `mem_wdata` hold their values. A transfer completes on a clock edge where both are high, and read data is taken from `mem_rdata` on that edge.
- R11: While reset is held, `req_ready` is 1 and `busy`, `mem_req` and `rescan` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can accept a request |
| req_id | input | MAX_IDBITS+1 | Interrupt ID |
| req_level | input | 1 | 1 = make pending, 0 = make not pending |
| lpi_en | input | 1 | Message interrupts enabled for this CPU |
| cfg_base | input | ADDR_W | Byte address of the configuration table |
| pend_base | input | ADDR_W | Byte address of the pending bitmap |
| id_bits_fld | input | FIELD_W | Programmed ID-width field |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_ack | input | 1 | Transfer completes on this edge |
| mem_rdata | input | 8 | Read byte, valid with `mem_ack` |
| busy | output | 1 | A request is in progress |
| rescan | output | 1 | One-cycle pulse: cached best interrupt is stale |

## Verification
If a request is accepted on edge N, the configuration read request appears after edge N+1, because the table checks take one cycle. Each later access starts in the cycle after the previous acknowledge. The rescan pulse is high for the one cycle after the last acknowledge, and ready returns one cycle after that. The memory model answers each transfer after a random wait of 0 to 2 cycles, so these times are not fixed. For that reason the scoreboard does not compare at fixed cycle counts. It compares each completed read, each write and each rescan pulse, in order, against the queue built by the driver, on the falling edge that follows the completing rising edge. After each request it also checks the access count and the byte stored in memory, once `busy` has fallen.

// File: rtl/lpi_pend_pkg.sv
package lpi_pend_pkg;
   localparam int BYTE_W     = 8;
   localparam int CFG_EN_BIT = 0;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CHECK,
      ST_CFG_RD,
      ST_PND_RD,
      ST_PND_WR,
      ST_DONE
   } eng_state_t;
endpackage

// File: rtl/lpi_req_filter.sv
module lpi_req_filter #(
   parameter int ID_W       = 16,
   parameter int ADDR_W     = 32,
   parameter int FIELD_W    = 5,
   parameter int MAX_IDBITS = 15,
   parameter int IDBITS_MIN = 13,
   parameter int LPI_FIRST  = 8192
) (
   input  logic               lpi_en,
   input  logic [ADDR_W-1:0]  cfg_base,
   input  logic [ADDR_W-1:0]  pend_base,
   input  logic [FIELD_W-1:0] id_bits_fld,
   input  logic [ID_W-1:0]    id,
   output logic               pass
);
   localparam int SH_W = FIELD_W + 1;

   logic [FIELD_W-1:0] eff_w;
   logic [SH_W-1:0]    shamt;
   logic [ID_W:0]      id_limit;

   always_comb begin
      // clamp the programmed width to what the block supports
      eff_w    = (id_bits_fld > FIELD_W'(MAX_IDBITS)) ? FIELD_W'(MAX_IDBITS) : id_bits_fld;
      shamt    = {1'b0, eff_w} + SH_W'(1);
      id_limit = {{ID_W{1'b0}}, 1'b1} << shamt;
      pass     = lpi_en
               && (cfg_base  != '0)
               && (pend_base != '0)
               && (eff_w >= FIELD_W'(IDBITS_MIN))
               && ({1'b0, id} <= id_limit)
               && (id >= ID_W'(LPI_FIRST));
   end
endmodule

// File: rtl/lpi_bit_merge.sv
module lpi_bit_merge #(
   parameter int BW = 8
) (
   input  logic [BW-1:0]         rd_byte,
   input  logic [$clog2(BW)-1:0] sel,
   input  logic                  level,
   output logic [BW-1:0]         new_byte,
   output logic                  changed
);
   localparam int SEL_W = $clog2(BW);

   for (genvar g = 0; g < BW; g++) begin : g_bit
      assign new_byte[g] = (sel == SEL_W'(g)) ? level : rd_byte[g];
   end

   assign changed = (rd_byte[sel] != level);
endmodule

// File: rtl/lpi_pend_engine.sv
module lpi_pend_engine
   import lpi_pend_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int FIELD_W    = 5,
   parameter int MAX_IDBITS = 15,
   parameter int IDBITS_MIN = 13,
   parameter int LPI_FIRST  = 8192,
   localparam int ID_W      = MAX_IDBITS + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic [ID_W-1:0]    req_id,
   input  logic               req_level,
   input  logic               lpi_en,
   input  logic [ADDR_W-1:0]  cfg_base,
   input  logic [ADDR_W-1:0]  pend_base,
   input  logic [FIELD_W-1:0] id_bits_fld,
   output logic               mem_req,
   output logic               mem_we,
   output logic [ADDR_W-1:0]  mem_addr,
   output logic [7:0]         mem_wdata,
   input  logic               mem_ack,
   input  logic [7:0]         mem_rdata,
   output logic               busy,
   output logic               rescan
);
   localparam int SEL_W = $clog2(BYTE_W);

   if (MAX_IDBITS >= (1 << FIELD_W)) begin : g_bad_field
      $error("FIELD_W too narrow for MAX_IDBITS");
   end
   if (IDBITS_MIN > MAX_IDBITS) begin : g_bad_min
      $error("IDBITS_MIN above MAX_IDBITS");
   end
   if (LPI_FIRST >= (1 << ID_W)) begin : g_bad_first
      $error("LPI_FIRST does not fit the ID width");
   end

   eng_state_t          st, st_nx;
   logic [ID_W-1:0]     id_q;
   logic                lvl_q;
   logic                en_q;
   logic [ADDR_W-1:0]   cfgb_q;
   logic [ADDR_W-1:0]   pendb_q;
   logic [FIELD_W-1:0]  fld_q;
   logic [BYTE_W-1:0]   wbyte_q;
   logic                accept;
   logic                chk_pass;
   logic [BYTE_W-1:0]   merged;
   logic                bit_chg;
   logic [ADDR_W-1:0]   cfg_addr;
   logic [ADDR_W-1:0]   pnd_addr;

   assign accept = req_valid && req_ready;

   // settings are captured with the request so a mid-flight change cannot split it
   lpi_req_filter #(
      .ID_W       (ID_W),
      .ADDR_W     (ADDR_W),
      .FIELD_W    (FIELD_W),
      .MAX_IDBITS (MAX_IDBITS),
      .IDBITS_MIN (IDBITS_MIN),
      .LPI_FIRST  (LPI_FIRST)
   ) u_filter (
      .lpi_en      (en_q),
      .cfg_base    (cfgb_q),
      .pend_base   (pendb_q),
      .id_bits_fld (fld_q),
      .id          (id_q),
      .pass        (chk_pass)
   );

   lpi_bit_merge #(
      .BW (BYTE_W)
   ) u_merge (
      .rd_byte  (mem_rdata),
      .sel      (id_q[SEL_W-1:0]),
      .level    (lvl_q),
      .new_byte (merged),
      .changed  (bit_chg)
   );

   assign cfg_addr = cfgb_q  + ADDR_W'(id_q - ID_W'(LPI_FIRST));
   assign pnd_addr = pendb_q + ADDR_W'(id_q >> SEL_W);

   always_comb begin
      st_nx = st;
      unique case (st)
         ST_IDLE:   if (accept) st_nx = ST_CHECK;
         ST_CHECK:  st_nx = chk_pass ? ST_CFG_RD : ST_IDLE;
         ST_CFG_RD: if (mem_ack) st_nx = mem_rdata[CFG_EN_BIT] ? ST_PND_RD : ST_IDLE;
         ST_PND_RD: if (mem_ack) st_nx = bit_chg ? ST_PND_WR : ST_DONE;
         ST_PND_WR: if (mem_ack) st_nx = ST_DONE;
         ST_DONE:   st_nx = ST_IDLE;
         default:   st_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         id_q    <= '0;
         lvl_q   <= 1'b0;
         en_q    <= 1'b0;
         cfgb_q  <= '0;
         pendb_q <= '0;
         fld_q   <= '0;
         wbyte_q <= '0;
      end else begin
         st <= st_nx;
         if (accept) begin
            id_q    <= req_id;
            lvl_q   <= req_level;
            en_q    <= lpi_en;
            cfgb_q  <= cfg_base;
            pendb_q <= pend_base;
            fld_q   <= id_bits_fld;
         end
         if (st == ST_PND_RD && mem_ack && bit_chg) begin
            wbyte_q <= merged;
         end
      end
   end

   always_comb begin
      req_ready = (st == ST_IDLE);
      busy      = (st != ST_IDLE);
      rescan    = (st == ST_DONE);
      mem_req   = (st == ST_CFG_RD) || (st == ST_PND_RD) || (st == ST_PND_WR);
      mem_we    = (st == ST_PND_WR);
      mem_wdata = (st == ST_PND_WR) ? wbyte_q : '0;
      mem_addr  = (st == ST_CFG_RD) ? cfg_addr :
                  (mem_req ? pnd_addr : '0);
   end
endmodule

// File: rtl/lpi_pend_engine_chk.sv
module lpi_pend_engine_chk #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              lpi_en,
   input logic              mem_req,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [7:0]        mem_wdata,
   input logic              mem_ack,
   input logic              busy,
   input logic              rescan
);
   assert_one_inflight_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   assert_mem_only_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> busy);

   assert_drop_disabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(req_valid && req_ready && !lpi_en) |=> !mem_req);

   assert_write_after_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we) |-> $past(mem_req && !mem_we && mem_ack));

   assert_rescan_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rescan |=> !rescan);

   assert_rescan_then_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rescan |=> req_ready);

   assert_hold_until_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=>
         (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

   assert_reset_quiet_R11: assert property (@(posedge clk)
      !rst_n |=> (!mem_req && !rescan));
endmodule

bind lpi_pend_engine lpi_pend_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .lpi_en    (lpi_en),
   .mem_req   (mem_req),
   .mem_we    (mem_we),
   .mem_addr  (mem_addr),
   .mem_wdata (mem_wdata),
   .mem_ack   (mem_ack),
   .busy      (busy),
   .rescan    (rescan)
);

// File: tb/tb_lpi_pend_engine.sv
module tb_lpi_pend_engine;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [15:0] req_id = '0;
   logic        req_level = 1'b0;
   logic        lpi_en = 1'b0;
   logic [31:0] cfg_base = '0;
   logic [31:0] pend_base = '0;
   logic [4:0]  id_bits_fld = '0;
   logic        mem_req, mem_we;
   logic [31:0] mem_addr;
   logic [7:0]  mem_wdata;
   logic        mem_ack = 1'b0;
   logic [7:0]  mem_rdata = '0;
   logic        busy, rescan;

   always #5 clk = ~clk;

   lpi_pend_engine dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_id(req_id), .req_level(req_level),
      .lpi_en(lpi_en), .cfg_base(cfg_base), .pend_base(pend_base), .id_bits_fld(id_bits_fld),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata), .busy(busy), .rescan(rescan)
   );

   typedef struct {
      int          kind;   // 0 read, 1 write, 2 rescan
      logic [31:0] addr;
      logic [7:0]  data;
      string       tag;
   } ev_t;

   ev_t         exp_q[$];
   logic [7:0]  mem [logic [31:0]];
   int          n_cmp = 0;
   int          n_bad = 0;
   int          n_acc = 0;
   int          n_wr  = 0;
   int          wcnt  = 0;
   int          lat   = 1;
   logic [31:0] first_addr = '0;
   logic [31:0] cap_addr = '0;
   logic [7:0]  cap_wdata = '0;
   logic        cap_we = 1'b0;

   function automatic logic [7:0] rdm(logic [31:0] a);
      return mem.exists(a) ? mem[a] : 8'h00;
   endfunction

   task automatic chk(string tag, string what, longint act, longint exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic sb_take(int kind, logic [31:0] addr, logic [7:0] data);
      ev_t e;
      if (exp_q.size() == 0) begin
         n_cmp++;
         n_bad++;
         $display("FAIL %s unexpected event kind %0d: actual addr %0h data %0h expected none",
                  (kind == 2) ? "R9" : ((kind == 1) ? "R8" : "R5"), kind, addr, data);
      end else begin
         e = exp_q.pop_front();
         chk(e.tag, "event kind/addr/data",
             {22'd0, kind[1:0], addr, data}, {22'd0, e.kind[1:0], e.addr, e.data});
      end
   endtask

   // memory model and monitor: both act on falling edges only
   always @(negedge clk) begin
      if (!rst_n) begin
         mem_ack = 1'b0;
         wcnt    = 0;
      end else begin
         if (mem_ack) begin
            mem_ack = 1'b0;
            n_acc++;
            if (cap_we) begin
               n_wr++;
               mem[cap_addr] = cap_wdata;
               sb_take(1, cap_addr, cap_wdata);
            end else begin
               sb_take(0, cap_addr, 8'h00);
            end
         end
         if (rescan) sb_take(2, 32'h0, 8'h00);
         if (mem_req && !mem_ack) begin
            if (wcnt == 0) first_addr = mem_addr;
            if (wcnt >= lat) begin
               if (lat > 0) chk("R10", "address held until ack", mem_addr, first_addr);
               cap_addr  = mem_addr;
               cap_we    = mem_we;
               cap_wdata = mem_wdata;
               mem_rdata = rdm(mem_addr);
               mem_ack   = 1'b1;
               wcnt      = 0;
               lat       = $urandom_range(0, 2);
            end else begin
               wcnt++;
            end
         end
      end
   end

   task automatic setcfg(int id, logic [7:0] v);
      mem[cfg_base + 32'(id - 8192)] = v;
   endtask

   // driver: derive expected traffic from the requirements, then issue the request
   task automatic send(int id, bit lvl, string tag);
      int          eff;
      bit          pass;
      bit          cfg_on;
      int          exp_acc;
      int          exp_wr;
      int          a0, w0;
      logic [31:0] ca, pa;
      logic [7:0]  pb, nb;
      ev_t         e;
      eff     = (id_bits_fld > 15) ? 15 : int'(id_bits_fld);
      pass    = lpi_en && (cfg_base != 0) && (pend_base != 0) && (eff >= 13)
                && (id <= (1 << (eff + 1))) && (id >= 8192);
      cfg_on  = 1'b0;
      exp_acc = 0;
      exp_wr  = 0;
      pa      = '0;
      nb      = '0;
      if (pass) begin
         ca = cfg_base + 32'(id - 8192);
         e.kind = 0; e.addr = ca; e.data = 8'h00; e.tag = "R5";
         exp_q.push_back(e);
         exp_acc = 1;
         if (rdm(ca)[0]) begin
            cfg_on = 1'b1;
            pa = pend_base + 32'(id / 8);
            e.kind = 0; e.addr = pa; e.data = 8'h00; e.tag = "R6";
            exp_q.push_back(e);
            exp_acc = 2;
            pb = rdm(pa);
            nb = pb;
            if (pb[id % 8] != lvl) begin
               nb[id % 8] = lvl;
               e.kind = 1; e.addr = pa; e.data = nb; e.tag = "R7";
               exp_q.push_back(e);
               exp_acc = 3;
               exp_wr  = 1;
            end
            e.kind = 2; e.addr = 32'h0; e.data = 8'h00; e.tag = "R9";
            exp_q.push_back(e);
         end
      end
      a0 = n_acc;
      w0 = n_wr;
      @(negedge clk);
      req_valid = 1'b1;
      req_id    = 16'(id);
      req_level = lvl;
      @(negedge clk);
      chk("R1", "ready low after accept", {req_ready, busy}, 2'b01);
      req_valid = 1'b0;
      while (busy) @(negedge clk);
      #2;
      chk(tag, "memory accesses", n_acc - a0, exp_acc);
      chk(exp_wr ? "R7" : "R8", "writes", n_wr - w0, exp_wr);
      chk("R9", "expected events left", exp_q.size(), 0);
      if (cfg_on) chk("R7", "stored pending byte", rdm(pa), nb);
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual still running expected finished");
      summary();
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      // R11: quiet state during reset
      chk("R11", "ready in reset", req_ready, 1);
      chk("R11", "busy in reset", busy, 0);
      chk("R11", "mem_req in reset", mem_req, 0);
      chk("R11", "rescan in reset", rescan, 0);
      rst_n = 1'b1;
      lpi_en = 1'b1;
      cfg_base = 32'h0000_1000;
      pend_base = 32'h0000_8000;
      id_bits_fld = 5'd15;
      mem[32'h0000_8400] = 8'h5A;

      setcfg(8192, 8'hA1); send(8192, 1'b1, "R6");   // clear bit set: 5A -> 5B
      send(8192, 1'b1, "R8");                         // already set: no write
      setcfg(8195, 8'h41); send(8195, 1'b0, "R7");   // set bit cleared: 5B -> 53
      setcfg(8194, 8'h01); send(8194, 1'b0, "R8");   // already clear: no write
      setcfg(8197, 8'h40); send(8197, 1'b1, "R5");   // entry disabled: one read only

      lpi_en = 1'b0;      send(8192, 1'b0, "R2"); lpi_en = 1'b1;
      cfg_base = 32'h0;   send(8192, 1'b0, "R2"); cfg_base = 32'h0000_1000;
      pend_base = 32'h0;  send(8192, 1'b0, "R2"); pend_base = 32'h0000_8000;

      id_bits_fld = 5'd12; send(8192, 1'b0, "R3");   // width below minimum
      id_bits_fld = 5'd13;
      setcfg(16384, 8'h01); send(16384, 1'b1, "R4"); // equal to limit: processed
      setcfg(16385, 8'h01); send(16385, 1'b1, "R4"); // above limit: dropped
      id_bits_fld = 5'd31;
      setcfg(65535, 8'h01); send(65535, 1'b1, "R3"); // clamped to 15
      send(8191, 1'b1, "R4");                        // below first message ID
      id_bits_fld = 5'd15;

      for (int i = 0; i < 150; i++) begin
         int rid;
         rid = 8192 + int'($urandom_range(0, 47));
         setcfg(rid, ($urandom_range(0, 3) == 0) ? 8'h80 : 8'h81);
         send(rid, 1'($urandom_range(0, 1)), "R6");
      end

      summary();
      $finish;
   end
endmodule